// File: doc/BRIEF.md
# Masked Bit Gather, Scatter and Count Unit

This unit performs mask-driven bit manipulation on a W-bit word (64 bits by default). A caller presents a source word, a mask word and a 10-bit operation code, then raises `start` for one cycle. The unit then walks the mask from bit 0 upward, handling one bit position per clock. One cycle after the walk ends it raises `done` for a single cycle, together with the result.

Five operations are offered:

- **Gather:** collects the source bits that sit under mask ones.
- **Scatter:** places the low source bits into the mask-one positions.
- **Split:** sorts the bits so that those under mask zeros sit above those under mask ones.
- **Leading-zero count:** counts zeros at the top of the gathered field only.
- **Trailing-zero count:** counts zeros at the bottom of the gathered field only.

An unknown code gets an immediate `done` with the `illegal` flag set and a zero result.

Results stay on `result` until a later accepted start replaces them. A start that arrives while the unit is busy is dropped.

Top module: `masked_bitops`

## Requirements
- R1: Op code 10'h0BC (gather) returns the source bits found at mask-one positions, packed from bit 0 upward in their original order; all bits at and above popcount(mask) are zero.
- R2: Op code 10'h09C (scatter) writes source bit 0 to the lowest mask-one position, source bit 1 to the next higher one, and so on; every mask-zero position of the result is zero.
- R3: Op code 10'h0DC (split) returns the gathered mask-zero bits shifted left by popcount(mask), ORed with the gathered mask-one bits; a zero mask returns the source itself and an all-ones mask returns the source.
- R4: Op code 10'h03B returns the number of zero bits counted downward from the top of the gathered field (bit popcount(mask)-1) until the first one. It equals popcount(mask) when the field holds no one, and it is 0 for a zero mask.
- R5: Op code 10'h23B returns the number of zero bits counted upward from bit 0 of the gathered field until the first one. It equals popcount(mask) when the field holds no one, and it is 0 for a zero mask.
- R6: A shift by the full width yields zero, so an all-ones mask gives the source for gather and scatter, and a count of W for a zero source.
- R7: Any other op code is flagged: the cycle after the start, `done` and `illegal` are 1, `result` is 0 and `busy` stays 0.
- R8: For a legal op, `busy` is 1 from the cycle after the start until `done` is raised. `done` is a single-cycle pulse arriving W+1 cycles after the start edge, and it is never high while `busy` is.
- R9: A start while `busy` is ignored and produces no extra `done`; `result` changes only in a cycle where `done` is high and holds its value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; sampled while idle |
| op | input | 10 | Operation code |
| src | input | W | Source word |
| mask | input | W | Mask word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| illegal | output | 1 | With done: op code was not recognised |
| result | output | W | Result, held between pulses |

## Verification
The bench builds the unit with W at its default of 64. This makes the full-width cases reachable: an all-ones mask gives a popcount of 64, which gives shifts by the whole word and counts of 64.

At that width, random masks mix with zero, all-ones, single-bit and alternating masks across all five operations. This covers the empty-field and empty-source corners of both zero counts. The same width also gives a 65-cycle window in which to inject a stray start mid-walk.

// File: rtl/masked_bitops.sv
module masked_bitops #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [9:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W + 1);
  localparam int IW = $clog2(W);
  localparam logic [9:0] OP_LZ  = 10'h03B;
  localparam logic [9:0] OP_EXT = 10'h0BC;
  localparam logic [9:0] OP_DEP = 10'h09C;
  localparam logic [9:0] OP_CFG = 10'h0DC;
  localparam logic [9:0] OP_TZ  = 10'h23B;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} st_t;
  typedef enum logic [2:0] {K_EXT, K_DEP, K_CFG, K_LZ, K_TZ} kind_t;

  st_t            st;
  kind_t          kind, kind_d;
  logic           legal;
  logic [W-1:0]   msk, psrc, dsrc;
  logic [W-1:0]   ones, zer, dep, res;
  logic [CW-1:0]  idx, k1, lz, tz;
  logic           seen, done_q, ill_q;
  logic           mb, sb;
  logic [IW-1:0]  widx;

  always_comb begin
    legal  = 1'b1;
    kind_d = K_EXT;
    case (op)
      OP_EXT:  kind_d = K_EXT;
      OP_DEP:  kind_d = K_DEP;
      OP_CFG:  kind_d = K_CFG;
      OP_LZ:   kind_d = K_LZ;
      OP_TZ:   kind_d = K_TZ;
      default: legal  = 1'b0;
    endcase
  end

  assign mb   = msk[0];
  assign sb   = psrc[0];
  assign widx = IW'(k1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_EXT;
      msk <= '0; psrc <= '0; dsrc <= '0;
      ones <= '0; zer <= '0; dep <= '0; res <= '0;
      idx <= '0; k1 <= '0; lz <= '0; tz <= '0;
      seen <= 1'b0; done_q <= 1'b0; ill_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (legal) begin
            st <= S_SCAN; kind <= kind_d;
            msk <= mask; psrc <= src; dsrc <= src;
            ones <= '0; zer <= '0; dep <= '0;
            idx <= '0; k1 <= '0; lz <= '0; tz <= '0; seen <= 1'b0;
          end else begin
            res <= '0; done_q <= 1'b1; ill_q <= 1'b1;
          end
        end
        S_SCAN: begin
          msk  <= msk >> 1;
          psrc <= psrc >> 1;
          dep  <= {mb & dsrc[0], dep[W-1:1]};
          if (mb) begin
            ones[widx] <= sb;
            k1   <= k1 + CW'(1);
            dsrc <= dsrc >> 1;
            if (sb) begin
              lz <= '0; seen <= 1'b1;
            end else begin
              lz <= lz + CW'(1);
              if (!seen) tz <= tz + CW'(1);
            end
          end else begin
            zer <= {sb, zer[W-1:1]};
          end
          idx <= idx + CW'(1);
          if (idx == CW'(W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          case (kind)
            K_EXT:   res <= ones;
            K_DEP:   res <= dep;
            K_CFG:   res <= zer | ones;
            K_LZ:    res <= W'(lz);
            default: res <= W'(tz);
          endcase
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign illegal = ill_q;
  assign result  = res;
endmodule

module masked_bitops_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [9:0]   op,
  input logic [W-1:0] mask,
  input logic         busy,
  input logic         done,
  input logic         illegal,
  input logic [W-1:0] result
);
  logic [W-1:0] cap_mask;
  logic [9:0]   cap_op;
  int           lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_mask <= '0; cap_op <= '0; lat <= 0;
    end else if (start && !busy) begin
      cap_mask <= mask; cap_op <= op; lat <= 0;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal |-> lat == W + 1);
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && result == '0 && !busy);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && cap_op == 10'h0BC |-> (result >> $countones(cap_mask)) == '0);
  a_r2_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && cap_op == 10'h09C |-> (result & ~cap_mask) == '0);
  a_r4_lz_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && cap_op == 10'h03B |-> result <= W'($countones(cap_mask)));
  a_r5_tz_range: assert property (@(posedge clk) disable iff (!rst_n)
    done && !illegal && cap_op == 10'h23B |-> result <= W'($countones(cap_mask)));
endmodule

bind masked_bitops masked_bitops_chk #(.W(W)) u_chk (.*);

// File: tb/sim_masked_bitops.sv
module sim_masked_bitops;
  localparam int W = 64;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [9:0] op = '0;
  logic [W-1:0] src = '0, mask = '0;
  logic busy, done, illegal;
  logic [W-1:0] result;
  int checks = 0, fails = 0;
  bit finished = 0;

  masked_bitops #(.W(W)) u0 (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pc(input logic [W-1:0] m);
    int n = 0;
    for (int i = 0; i < W; i++) n += m[i];
    return n;
  endfunction
  function automatic logic [W-1:0] gather(input logic [W-1:0] s, input logic [W-1:0] m, input bit pol);
    logic [W-1:0] r = '0; int k = 0;
    for (int i = 0; i < W; i++) if (m[i] == pol) begin r[k] = s[i]; k++; end
    return r;
  endfunction
  function automatic logic [W-1:0] scatter(input logic [W-1:0] s, input logic [W-1:0] m);
    logic [W-1:0] r = '0; int k = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    return r;
  endfunction
  function automatic logic [W-1:0] refval(input logic [9:0] o, input logic [W-1:0] s, input logic [W-1:0] m);
    int p = pc(m); logic [W-1:0] g = gather(s, m, 1'b1); int c = 0;
    case (o)
      10'h0BC: return g;
      10'h09C: return scatter(s, m);
      10'h0DC: begin
        logic [W-1:0] z = gather(s, m, 1'b0);
        for (int i = 0; i < W; i++) if (i >= p) g[i] = z[i - p];
        return g;
      end
      10'h03B: begin
        for (int i = p - 1; i >= 0; i--) begin if (g[i]) break; c++; end
        return W'(c);
      end
      default: begin
        for (int i = 0; i < p; i++) begin if (g[i]) break; c++; end
        return W'(c);
      end
    endcase
  endfunction

  function automatic string rq(input logic [9:0] o, input logic [W-1:0] m, input logic [W-1:0] s);
    if (m == '1 || (s == '0 && m != '0 && (o == 10'h03B || o == 10'h23B))) return "R6";
    case (o)
      10'h0BC: return "R1";
      10'h09C: return "R2";
      10'h0DC: return "R3";
      10'h03B: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input logic [9:0] o, input logic [W-1:0] s, input logic [W-1:0] m, input bit inject);
    logic [W-1:0] exp = refval(o, s, m);
    bit early = 0;
    @(negedge clk); op = o; src = s; mask = m; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R8 busy after start", W'(busy), W'(1));
    for (int j = 1; j <= W; j++) begin
      if (inject && j == 5) begin op = 10'h0BC; src = ~s; mask = '1; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (done) early = 1;
    end
    start = 1'b0;
    chk(!early, "R8 early done", W'(early), '0);
    @(negedge clk);
    chk(done === 1'b1 && illegal === 1'b0, "R8 done timing", W'(done), W'(1));
    chk(result === exp, rq(o, m, s), result, exp);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, inject ? "R9 stray start" : "R8 pulse", W'(done), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [9:0] ops [5] = '{10'h0BC, 10'h09C, 10'h0DC, 10'h03B, 10'h23B};
    logic [W-1:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result === '0, "R8 reset", result, '0);
    for (int k = 0; k < 5; k++) begin
      run(ops[k], 64'h0123_4567_89AB_CDEF, '0, 0);
      run(ops[k], 64'hF0F0_1234_0000_8001, '1, 0);
      run(ops[k], '0, '1, 0);
      run(ops[k], '0, 64'h00FF_0000_0F00_00F0, 0);
      run(ops[k], '1, 64'h8000_0000_0000_0000, 0);
      run(ops[k], 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0002, 0);
      run(ops[k], 64'hDEAD_BEEF_CAFE_F00D, 64'hAAAA_AAAA_AAAA_AAAA, 0);
      run(ops[k], 64'h1000_0000_0000_0100, 64'hFFFF_0000_FFFF_0000, 0);
      for (int r = 0; r < 6; r++)
        run(ops[k], {$urandom, $urandom}, {$urandom, $urandom}, 0);
    end
    run(10'h03B, 64'h0000_0040_0000_0000, 64'h00FF_FF00_0000_0000, 1);
    keep = result;
    repeat (5) @(negedge clk);
    chk(result === keep && done === 1'b0, "R9 hold", result, keep);
    @(negedge clk); op = 10'h123; src = '1; mask = '1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done === 1'b1 && illegal === 1'b1 && busy === 1'b0, "R7 flag", W'(illegal), W'(1));
    chk(result === '0, "R7 result", result, '0);
    @(negedge clk);
    chk(done === 1'b0 && illegal === 1'b0, "R7 pulse", W'(done), '0);
    run(10'h23B, 64'h0000_0000_0000_0800, 64'h0000_0000_0000_FF00, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule